// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block controls a byte-wide non-volatile array for a small 8-bit processor. The array itself is modelled as an inferable synchronous RAM. Software drives the block through one control byte at a fixed bus address. The byte holds a program-mode bit, an erase-mode bit, a whole-array selector and a high-voltage enable. Every other address in the window reaches the array. The control byte enforces interlocks: high voltage can only switch on once a mode is already chosen, and the mode cannot change while high voltage is on.

With program mode and high voltage both on, array writes can only pull bits from 1 to 0. The first write of a session picks one aligned row, and the session accepts at most one row's worth of writes. With erase mode and high voltage both on, a single array write starts an erase. The erase covers either the aligned page holding that address or, with the whole-array selector set, every byte. The erase walks its region one byte per clock while a busy flag is raised. Array read data appears in the cycle after the read request.

Top module: `flash_seq`

## Requirements
- R1: After reset the control byte reads 0x00, and both busy and prog_err are 0.
- R2: The control byte holds program mode in bit 0, erase mode in bit 1, whole-array select in bit 2 and high-voltage enable in bit 3. Bits 7 to 4 always read 0. Read data for any address is presented in the cycle after the read request.
- R3: A control write with bit 3 set turns high voltage on only if the mode bit (program or erase) was already 1 before that write and remains 1 after it. Otherwise bit 3 stays 0.
- R4: While high voltage is on, writes to control bits 2 to 0 are ignored. Writing 0 to bit 3 turns high voltage off and ends the session, leaving the mode bits unchanged.
- R5: A control write with both bit 0 and bit 1 set, made while high voltage is off, sets erase mode and clears program mode.
- R6: During a program session, an accepted array write stores the old byte AND the written byte. A read issued in the next cycle, or after back-to-back writes to the same byte, returns the combined value.
- R7: The first array write of a program session selects the aligned 32-byte row that holds its address. Writes outside that row are ignored and set prog_err.
- R8: A program session accepts at most 32 array writes. Further writes are ignored and set prog_err. prog_err stays set until a new program session starts, which clears it.
- R9: An array write during an erase session with bit 2 clear sets every byte of the aligned 64-byte page that holds the address to 0xFF. Busy is held for exactly 64 cycles, and other pages are not touched.
- R10: An array write during an erase session with bit 2 set sets every array byte to 0xFF. Busy is held for as many cycles as the array has bytes.
- R11: While busy is high, array reads return 0xFF, and control writes have no effect.
- R12: Array writes made while high voltage is off change no stored byte and leave prog_err unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address: array below ARRAY_BYTES, control byte at CTRL_ADDR |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read request |
| busy | output | 1 | Erase in progress |
| prog_err | output | 1 | Sticky flag for a rejected program write |

## Verification
The assertions check the interlocks on every cycle. High voltage never stands without a mode, the two mode bits are never both set, and the mode bits stay frozen while high voltage is on. The assertions also check that reads during busy return 0xFF, that every busy run lasts exactly a page or the whole array, and that prog_err only rises during a program session. Only the bench scenarios can show what the array holds. These scenarios cover AND-accumulation across sessions and back-to-back writes, the row limit and row lock, and page erase leaving neighbouring pages intact. They are checked by sweeping every address against values the bench computes.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
  // Control byte layout, low nibble; upper nibble reads as zero
  typedef struct packed {
    logic hv;     // bit 3
    logic whole;  // bit 2
    logic erase;  // bit 1
    logic pgm;    // bit 0
  } ctrl_t;

  localparam int unsigned PGM_BIT   = 0;
  localparam int unsigned ERASE_BIT = 1;
  localparam int unsigned WHOLE_BIT = 2;
  localparam int unsigned HV_BIT    = 3;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;

  function automatic logic [7:0] ctrl_byte(input ctrl_t c);
    return {4'b0000, c};
  endfunction
endpackage

// File: rtl/fsq_ctrl_reg.sv
module fsq_ctrl_reg
  import fsq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       busy,
  output ctrl_t      ctrl
);
  ctrl_t nxt;

  always_comb begin
    nxt = ctrl;
    if (ctrl.hv) begin
      // modes frozen while high voltage is on; only hv may drop
      nxt.hv = wdata[HV_BIT];
    end else begin
      nxt.erase = wdata[ERASE_BIT];
      nxt.pgm   = wdata[PGM_BIT] & ~wdata[ERASE_BIT];
      nxt.whole = wdata[WHOLE_BIT];
      nxt.hv    = wdata[HV_BIT] &
                  ((ctrl.pgm & nxt.pgm) | (ctrl.erase & nxt.erase));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (wr_en && !busy) begin
      ctrl <= nxt;
    end
  end
endmodule

// File: rtl/fsq_prog_window.sv
module fsq_prog_window #(
  parameter int unsigned AW        = 9,
  parameter int unsigned ROW_BYTES = 32
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               active,
  input  logic                               wr_en,
  input  logic [AW-$clog2(ROW_BYTES)-1:0]    row_addr,
  output logic                               accept,
  output logic                               err
);
  localparam int unsigned ROW_AW = $clog2(ROW_BYTES);
  localparam int unsigned RW     = AW - ROW_AW;
  localparam int unsigned CW     = $clog2(ROW_BYTES + 1);

  logic [RW-1:0] row_q;
  logic          row_valid;
  logic [CW-1:0] cnt_q;
  logic          active_q;
  logic          row_hit;
  logic          room;

  assign row_hit = (row_q == row_addr);
  assign room    = (cnt_q != CW'(ROW_BYTES));
  assign accept  = wr_en & active & (~row_valid | (row_hit & room));

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q     <= '0;
      row_valid <= 1'b0;
      cnt_q     <= '0;
      active_q  <= 1'b0;
      err       <= 1'b0;
    end else begin
      active_q <= active;
      if (!active) begin
        row_valid <= 1'b0;
        cnt_q     <= '0;
      end else if (accept) begin
        row_valid <= 1'b1;
        row_q     <= row_addr;
        cnt_q     <= cnt_q + CW'(1);
      end
      if (active && !active_q) begin
        err <= 1'b0;
      end else if (wr_en && active && !accept) begin
        err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fsq_erase_seq.sv
module fsq_erase_seq #(
  parameter int unsigned AW          = 9,
  parameter int unsigned PAGE_BYTES  = 64,
  parameter int unsigned ARRAY_BYTES = 256
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               start,
  input  logic                               whole,
  input  logic [AW-$clog2(PAGE_BYTES)-1:0]   page_idx,
  output logic                               busy,
  output logic                               we,
  output logic [AW-1:0]                      waddr
);
  localparam int unsigned PAGE_AW = $clog2(PAGE_BYTES);
  localparam int unsigned PW      = AW - PAGE_AW;

  logic [PW-1:0] page_q;
  logic          whole_q;
  logic [AW-1:0] cnt_q;
  logic          last;

  assign last  = whole_q ? (cnt_q == AW'(ARRAY_BYTES - 1))
                         : (cnt_q[PAGE_AW-1:0] == PAGE_AW'(PAGE_BYTES - 1));
  assign waddr = whole_q ? cnt_q : {page_q, cnt_q[PAGE_AW-1:0]};
  assign we    = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      whole_q <= 1'b0;
      page_q  <= '0;
      cnt_q   <= '0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        whole_q <= whole;
        page_q  <= page_idx;
        cnt_q   <= '0;
      end
    end else if (last) begin
      busy <= 1'b0;
    end else begin
      cnt_q <= cnt_q + AW'(1);
    end
  end
endmodule

// File: rtl/fsq_array.sv
module fsq_array #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata
);
  logic [7:0] mem [DEPTH];

  // simple dual port, read-before-write
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import fsq_pkg::*;
#(
  parameter int unsigned ARRAY_BYTES = 512,
  parameter int unsigned PAGE_BYTES  = 64,
  parameter int unsigned ROW_BYTES   = 32,
  parameter int unsigned ADDR_W      = $clog2(ARRAY_BYTES) + 1,
  parameter int unsigned CTRL_ADDR   = ARRAY_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              busy,
  output logic              prog_err
);
  localparam int unsigned AAW     = $clog2(ARRAY_BYTES);
  localparam int unsigned ROW_AW  = $clog2(ROW_BYTES);
  localparam int unsigned PAGE_AW = $clog2(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] ARR_END = ADDR_W'(ARRAY_BYTES);
  localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_ADDR);

  ctrl_t ctrl;
  logic  ctrl_pgm, ctrl_erase, ctrl_whole, ctrl_hv;

  logic           in_array, is_ctrl;
  logic           array_wr, ctrl_wr, rd_req;
  logic [AAW-1:0] arr_addr;
  logic           win_accept, erase_start;
  logic           er_we;
  logic [AAW-1:0] er_waddr;
  logic [7:0]     mem_q;

  // program read-modify-write stage
  logic           pend_valid;
  logic [AAW-1:0] pend_addr;
  logic [7:0]     pend_data;
  logic           prev_valid;
  logic [AAW-1:0] prev_addr;
  logic [7:0]     prev_val;
  logic [7:0]     wr_val;
  logic           fwd_hit;

  logic           mem_we;
  logic [AAW-1:0] mem_waddr;
  logic [7:0]     mem_wdata;

  logic           rd_use_mem;
  logic [7:0]     rd_reg;

  assign in_array = (bus_addr < ARR_END);
  assign is_ctrl  = (bus_addr == CTRL_A);
  assign arr_addr = bus_addr[AAW-1:0];
  assign array_wr = bus_sel & bus_we & in_array;
  assign ctrl_wr  = bus_sel & bus_we & is_ctrl;
  assign rd_req   = bus_sel & ~bus_we;

  assign ctrl_pgm   = ctrl.pgm;
  assign ctrl_erase = ctrl.erase;
  assign ctrl_whole = ctrl.whole;
  assign ctrl_hv    = ctrl.hv;

  fsq_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .wr_en (ctrl_wr),
    .wdata (bus_wdata),
    .busy  (busy),
    .ctrl  (ctrl)
  );

  fsq_prog_window #(
    .AW        (AAW),
    .ROW_BYTES (ROW_BYTES)
  ) u_window (
    .clk      (clk),
    .rst      (rst),
    .active   (ctrl_pgm & ctrl_hv),
    .wr_en    (array_wr & ~busy),
    .row_addr (arr_addr[AAW-1:ROW_AW]),
    .accept   (win_accept),
    .err      (prog_err)
  );

  assign erase_start = array_wr & ctrl_erase & ctrl_hv & ~busy;

  fsq_erase_seq #(
    .AW          (AAW),
    .PAGE_BYTES  (PAGE_BYTES),
    .ARRAY_BYTES (ARRAY_BYTES)
  ) u_erase (
    .clk      (clk),
    .rst      (rst),
    .start    (erase_start),
    .whole    (ctrl_whole),
    .page_idx (arr_addr[AAW-1:PAGE_AW]),
    .busy     (busy),
    .we       (er_we),
    .waddr    (er_waddr)
  );

  // stored & new, with bypass when the previous cycle wrote the same byte
  assign wr_val  = ((prev_valid && prev_addr == pend_addr) ? prev_val : mem_q) & pend_data;
  assign fwd_hit = pend_valid && (pend_addr == arr_addr);

  always_comb begin
    if (er_we) begin
      mem_we    = 1'b1;
      mem_waddr = er_waddr;
      mem_wdata = ERASED_BYTE;
    end else begin
      mem_we    = pend_valid;
      mem_waddr = pend_addr;
      mem_wdata = wr_val;
    end
  end

  fsq_array #(
    .DEPTH (ARRAY_BYTES),
    .AW    (AAW)
  ) u_array (
    .clk   (clk),
    .raddr (arr_addr),
    .rdata (mem_q),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
      pend_addr  <= '0;
      pend_data  <= '0;
      prev_valid <= 1'b0;
      prev_addr  <= '0;
      prev_val   <= '0;
      rd_use_mem <= 1'b0;
      rd_reg     <= '0;
    end else begin
      pend_valid <= win_accept;
      pend_addr  <= arr_addr;
      pend_data  <= bus_wdata;
      prev_valid <= pend_valid;
      prev_addr  <= pend_addr;
      prev_val   <= wr_val;
      if (rd_req) begin
        rd_use_mem <= in_array & ~busy & ~fwd_hit;
        if (is_ctrl)                rd_reg <= ctrl_byte(ctrl);
        else if (in_array && busy)  rd_reg <= ERASED_BYTE;
        else if (in_array)          rd_reg <= wr_val;
        else                        rd_reg <= 8'h00;
      end
    end
  end

  assign bus_rdata = rd_use_mem ? mem_q : rd_reg;
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
  parameter int unsigned ARRAY_BYTES = 512,
  parameter int unsigned PAGE_BYTES  = 64,
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned CTRL_ADDR   = 512
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rdata,
  input logic              busy,
  input logic              prog_err,
  input logic              pgm,
  input logic              erase,
  input logic              whole,
  input logic              hv
);
  localparam logic [ADDR_W-1:0] ARR_END = ADDR_W'(ARRAY_BYTES);
  localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_ADDR);

  int unsigned run_len;
  always_ff @(posedge clk) begin
    if (rst)       run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  // R3
  hv_needs_mode_chk: assert property (@(posedge clk) disable iff (rst)
    hv |-> (pgm || erase));

  // R5
  modes_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(pgm && erase));

  // R4
  modes_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (hv && $past(hv)) |-> ($stable(pgm) && $stable(erase) && $stable(whole)));

  // R2
  ctrl_readback_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_we && bus_addr == CTRL_A) |=>
      (bus_rdata == {4'b0000, $past(hv), $past(whole), $past(erase), $past(pgm)}));

  // R11
  busy_read_ff_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_we && bus_addr < ARR_END && busy) |=> (bus_rdata == 8'hFF));

  // R11
  busy_in_erase_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (erase && hv));

  // R9 R10
  busy_length_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == PAGE_BYTES || run_len == ARRAY_BYTES));

  // R7 R8
  err_only_in_prog_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(prog_err) |-> $past(pgm && hv));
endmodule

bind flash_seq flash_seq_chk #(
  .ARRAY_BYTES (ARRAY_BYTES),
  .PAGE_BYTES  (PAGE_BYTES),
  .ADDR_W      (ADDR_W),
  .CTRL_ADDR   (CTRL_ADDR)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .busy      (busy),
  .prog_err  (prog_err),
  .pgm       (ctrl_pgm),
  .erase     (ctrl_erase),
  .whole     (ctrl_whole),
  .hv        (ctrl_hv)
);

// File: tb/flash_seq_tb.sv
`timescale 1ns/100ps
module flash_seq_tb;
  localparam int NB = 256;
  localparam int AW = 9;
  localparam logic [AW-1:0] CA = AW'(NB);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic          busy;
  logic          prog_err;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] model [NB];

  always #2.5 clk = ~clk;

  flash_seq #(
    .ARRAY_BYTES (NB),
    .PAGE_BYTES  (64),
    .ROW_BYTES   (32),
    .ADDR_W      (AW),
    .CTRL_ADDR   (NB)
  ) u_dut (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .prog_err  (prog_err)
  );

  function automatic logic [7:0] fa(input int i);
    return 8'((i * 37) ^ 8'h5A);
  endfunction
  function automatic logic [7:0] fb(input int i);
    return 8'(i * 11 + 3);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy === 1'b1 && n < 10000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic sweep(input string req);
    logic [7:0] d;
    for (int i = 0; i < NB; i++) begin
      rd(AW'(i), d);
      chk(req, d, model[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(CA, d); chk("R1 ctrl", d, 8'h00);
    chk("R1 busy", {7'd0, busy}, 8'h00);
    chk("R1 err", {7'd0, prog_err}, 8'h00);

    // R3 interlock on high voltage
    wr(CA, 8'h08); rd(CA, d); chk("R3 hv alone", d, 8'h00);
    wr(CA, 8'h09); rd(CA, d); chk("R3 hv with new mode", d, 8'h01);
    wr(CA, 8'h09); rd(CA, d); chk("R3 hv with prior mode", d, 8'h09);
    // R4 freeze and end
    wr(CA, 8'h0E); rd(CA, d); chk("R4 modes frozen", d, 8'h09);
    wr(CA, 8'h01); rd(CA, d); chk("R4 hv off keeps mode", d, 8'h01);
    wr(CA, 8'h00); rd(CA, d); chk("R2 cleared", d, 8'h00);
    // R2 upper bits
    wr(CA, 8'hF4); rd(CA, d); chk("R2 upper nibble zero", d, 8'h04);
    // R5 both modes
    wr(CA, 8'h03); rd(CA, d); chk("R5 erase wins", d, 8'h02);
    wr(CA, 8'h00);

    // R10 whole-array erase
    wr(CA, 8'h06); wr(CA, 8'h0E); rd(CA, d); chk("R10 ctrl", d, 8'h0E);
    wr(AW'(5), 8'h00);
    count_busy(n); chk("R10 busy cycles", 8'(n), 8'(NB));
    wr(CA, 8'h06); rd(CA, d); chk("R4 hv off", d, 8'h06);
    wr(CA, 8'h00);
    for (int i = 0; i < NB; i++) model[i] = 8'hFF;
    sweep("R10 erased");

    // R12 write with high voltage off
    wr(CA, 8'h01);
    wr(AW'(100), 8'h00); rd(AW'(100), d); chk("R12 no change", d, 8'hFF);
    chk("R12 err", {7'd0, prog_err}, 8'h00);

    // R6 R8 program session over row 2
    wr(CA, 8'h09);
    for (int i = 0; i < 32; i++) begin
      wr(AW'(64 + i), fa(i));
      model[64 + i] = fa(i);
    end
    chk("R8 full row err", {7'd0, prog_err}, 8'h00);
    wr(AW'(64), 8'h00);
    chk("R8 33rd err", {7'd0, prog_err}, 8'h01);
    rd(AW'(64), d); chk("R8 33rd ignored", d, fa(0));
    for (int i = 0; i < 32; i++) begin
      rd(AW'(64 + i), d); chk("R6 programmed", d, fa(i));
    end
    wr(CA, 8'h01);

    // R8 err clears on new session; R6 AND and forwarding; R7 row lock
    wr(CA, 8'h09); rd(CA, d); chk("R3 session", d, 8'h09);
    chk("R8 err cleared", {7'd0, prog_err}, 8'h00);
    wr(AW'(200), 8'hF0); wr(AW'(200), 8'h3C);
    rd(AW'(200), d); chk("R6 and back-to-back", d, 8'h30);
    model[200] = 8'h30;
    for (int i = 0; i < 30; i++) begin
      wr(AW'(192 + i), fb(i));
      model[192 + i] = model[192 + i] & fb(i);
    end
    chk("R7 in-row err", {7'd0, prog_err}, 8'h00);
    wr(AW'(10), 8'h00);
    chk("R7 out-of-row err", {7'd0, prog_err}, 8'h01);
    rd(AW'(10), d); chk("R7 ignored", d, 8'hFF);
    wr(CA, 8'h01); wr(CA, 8'h00);
    sweep("R6 array");

    // R9 page erase, R11 during busy
    wr(CA, 8'h02); wr(CA, 8'h0A);
    wr(AW'(70), 8'h00);
    rd(AW'(200), d); chk("R11 busy read", d, 8'hFF);
    wr(CA, 8'h00);
    rd(CA, d); chk("R11 ctrl write ignored", d, 8'h0A);
    count_busy(n); chk("R9 busy cycles", 8'(n), 8'(64 - 3));
    wr(CA, 8'h02); wr(CA, 8'h00);
    for (int i = 64; i < 128; i++) model[i] = 8'hFF;
    sweep("R9 page");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule